// File: doc/BRIEF.md
# Rotating Register Loop Controller

This block gives hardware support to software-pipelined loops so that one kernel body also serves as the prologue and the epilogue. It keeps a rotation base for the rotating general registers and another for the rotating predicates. It holds the stage-predicate bits, a loop counter and a drain counter. Each loop-closing branch moves the register names by one position, shifts the stage predicates by one, and decides whether the branch goes back to the top of the kernel.

Before a loop, a setup strobe loads the loop and drain counts and clears both rotation bases and all stage predicates. While the loop runs, each branch is presented with `br_valid`. In counted mode the loop counter drives the decision. In while mode a qualifying predicate replaces that test. The decode stage uses the combinational rename ports to turn logical register and predicate numbers into physical ones. A read port returns the current value of any logical stage predicate.

Top module: `rotating_loop_ctrl`

## Requirements
- R1: After reset, both rotation bases are 0. The loop count and drain count read 0, every rotating predicate reads 0, and `br_taken` is 0.
- R2: A logical general register L with 32 <= L <= 127 maps to 32 + ((L - 32 + gbase) mod 96). Registers below 32 map to themselves.
- R3: Each branch decrements the general base modulo 96, so it wraps from 0 to 95. The physical register named by logical r32 before a branch is named by r33 after it.
- R4: A logical predicate L with 16 <= L <= 63 maps to 16 + ((L - 16 + pbase) mod 48). Predicates below 16 map to themselves and read value 0. Each branch decrements pbase modulo 48.
- R5: On each branch the value of logical pK moves to pK+1 for 16 <= K < 63, and p16 receives the new stage bit.
- R6: In counted mode (`br_mode`=0) with a nonzero loop count, the branch is taken, the loop count decrements, p16 becomes 1 and the drain count is unchanged.
- R7: In counted mode with a loop count of 0 and a drain count above 1, the branch is taken, the drain count decrements and p16 becomes 0. The drain count never increases on a branch.
- R8: In counted mode with a loop count of 0 and a drain count of 0 or 1, the branch falls through (`br_taken`=0). The drain count ends at 0, p16 becomes 0 and the names still rotate.
- R9: In while mode (`br_mode`=1) the loop count never changes. With `br_qp`=1 the branch is taken, p16 becomes 1 and the drain count is unchanged. With `br_qp`=0 the drain rules of R7 and R8 apply.
- R10: `setup_en` loads both counts, clears both bases and clears every rotating predicate. It takes priority over a branch in the same cycle, and that branch neither rotates nor reports taken.
- R11: `br_taken` is combinational and is high only in a cycle with `br_valid`. A cycle without `br_valid` or `setup_en` changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| setup_en | input | 1 | Load counts and clear bases and predicates |
| setup_lc | input | LC_W | Loop count to load |
| setup_ec | input | EC_W | Drain count to load |
| br_valid | input | 1 | Loop branch executes this cycle |
| br_mode | input | 1 | 0 counted, 1 while |
| br_qp | input | 1 | Qualifying predicate for while mode |
| gr_log_idx | input | 7 | Logical general register number |
| gr_phys_idx | output | 7 | Renamed general register number |
| pr_log_idx | input | 6 | Logical predicate number |
| pr_phys_idx | output | 6 | Renamed predicate number |
| pr_value | output | 1 | Current value of the logical predicate |
| br_taken | output | 1 | Branch decision |
| lc_value | output | LC_W | Current loop count |
| ec_value | output | EC_W | Current drain count |

## Verification
The bench builds the block with its default sizes: 96 rotating general registers, 48 rotating predicates, a 16-bit loop count and a 6-bit drain count. With these sizes the first branch already carries both bases across their wrap from 0 to the top value. A short counted loop walks every decision arm in a few cycles: kernel, drain, the final fall-through, and a drain count of zero. The modelled predicate pipeline is compared on p16 to p20 after every branch, so the bench sees the stage bits travel one step per iteration.

// File: rtl/rlc_pkg.sv
// Package: shared types for the rotating register loop controller.
// Assumes: single clock domain; one loop branch per cycle at most.
package rlc_pkg;
    typedef enum logic {
        MODE_COUNTED = 1'b0,
        MODE_WHILE   = 1'b1
    } loop_mode_e;
endpackage

// File: rtl/rlc_rot_base.sv
// Rotation base and renamer for one rotating register region.
// Holds a base in [0, NROT) that steps down modulo NROT on each rotation.
// It maps NPORTS logical indices into physical ones. An index below FIRST
// passes through unchanged.
// Assumes: FIRST + NROT <= 2**IDX_W and clear has priority over rotate.
module rlc_rot_base #(
    parameter int FIRST  = 32,
    parameter int NROT   = 96,
    parameter int IDX_W  = 7,
    parameter int NPORTS = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear,
    input  logic                          rotate,
    input  logic [NPORTS-1:0][IDX_W-1:0]  log_idx,
    output logic [NPORTS-1:0][IDX_W-1:0]  phys_idx
);
    localparam int BW = $clog2(NROT);
    localparam logic [BW-1:0]  TOP_BASE = BW'(NROT - 1);
    localparam logic [IDX_W:0] NROT_X   = (IDX_W+1)'(NROT);
    localparam logic [IDX_W:0] FIRST_X  = (IDX_W+1)'(FIRST);

    logic [BW-1:0] base_q;

    // Base register: cleared on setup, stepped down modulo NROT on rotation.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            base_q <= '0;
        end else if (rotate) begin
            base_q <= (base_q == '0) ? TOP_BASE : base_q - 1'b1;
        end
    end

    // One renaming lane per lookup port.
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic [IDX_W:0] lx, off, sum, wrapped;

        // Compute the offset into the region, add the base and wrap once.
        always_comb begin
            lx      = {1'b0, log_idx[p]};
            off     = lx - FIRST_X;
            sum     = off + (IDX_W+1)'(base_q);
            wrapped = (sum >= NROT_X) ? sum - NROT_X : sum;
            if (lx < FIRST_X) begin
                phys_idx[p] = log_idx[p];
            end else begin
                phys_idx[p] = IDX_W'(wrapped + FIRST_X);
            end
        end
    end

    AST_BASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(base_q) < NROT)); // R3
    AST_BASE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (rotate && !clear) |=> (base_q != $past(base_q))); // R3
    AST_BASE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (base_q == '0)); // R10
    AST_BASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rotate && !clear) |=> $stable(base_q)); // R11
endmodule

// File: rtl/rlc_pred_file.sv
// Stage-predicate storage for the rotating predicate region.
// Holds one bit per physical rotating predicate. On rotation, the slot that
// becomes the new lowest logical predicate receives the stage bit.
// Assumes: wr_phys is the physical slot of the highest logical rotating
// predicate under the current base, and indices are within the region.
module rlc_pred_file #(
    parameter int FIRST = 16,
    parameter int NROT  = 48,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             rotate,
    input  logic             stage_bit,
    input  logic [IDX_W-1:0] wr_phys,
    input  logic [IDX_W-1:0] rd_phys,
    output logic             rd_val
);
    localparam int SW = $clog2(NROT);
    localparam logic [IDX_W-1:0] FIRST_I = IDX_W'(FIRST);

    logic [NROT-1:0] bits_q;
    logic [SW-1:0]   wr_slot;
    logic [SW-1:0]   rd_slot;

    // Convert physical numbers into slot positions inside the region.
    always_comb begin
        wr_slot = SW'(wr_phys - FIRST_I);
        rd_slot = SW'(rd_phys - FIRST_I);
    end

    // Read: predicates below the region hold no stage bit and read 0.
    always_comb begin
        rd_val = (rd_phys >= FIRST_I) ? bits_q[rd_slot] : 1'b0;
    end

    // Storage: cleared on setup, one slot written per rotation.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            bits_q <= '0;
        end else if (rotate) begin
            bits_q[wr_slot] <= stage_bit;
        end
    end

    AST_STAGE_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rotate && !clear) |=> (bits_q[$past(wr_slot)] == $past(stage_bit))); // R5
    AST_PRED_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (bits_q == '0)); // R10
    AST_PRED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rotate && !clear) |=> $stable(bits_q)); // R11
endmodule

// File: rtl/rlc_loop_ctl.sv
// Loop decision and counters.
// Decides whether a loop branch is taken, which stage bit enters the
// predicate pipeline, and how the loop and drain counts move.
// Assumes: setup_en has priority over br_valid.
module rlc_loop_ctl
    import rlc_pkg::*;
#(
    parameter int LC_W = 16,
    parameter int EC_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            setup_en,
    input  logic [LC_W-1:0] setup_lc,
    input  logic [EC_W-1:0] setup_ec,
    input  logic            br_valid,
    input  loop_mode_e      br_mode,
    input  logic            br_qp,
    output logic            br_taken,
    output logic            stage_bit,
    output logic [LC_W-1:0] lc_value,
    output logic [EC_W-1:0] ec_value
);
    localparam logic [EC_W-1:0] EC_ONE = EC_W'(1);

    logic [LC_W-1:0] lc_q, lc_d;
    logic [EC_W-1:0] ec_q, ec_d;
    logic            keep_going;
    logic            taken_raw;

    // Kernel test: loop count in counted mode, qualifying predicate in while mode.
    always_comb begin
        keep_going = (br_mode == MODE_WHILE) ? br_qp : (lc_q != '0);
    end

    // Next counts, decision and stage bit for a branch in this cycle.
    always_comb begin
        lc_d      = lc_q;
        ec_d      = ec_q;
        taken_raw = 1'b0;
        stage_bit = 1'b0;
        if (keep_going) begin
            taken_raw = 1'b1;
            stage_bit = 1'b1;
            if (br_mode == MODE_COUNTED) begin
                lc_d = lc_q - 1'b1;
            end
        end else if (ec_q > EC_ONE) begin
            taken_raw = 1'b1;
            ec_d      = ec_q - 1'b1;
        end else if (ec_q == EC_ONE) begin
            ec_d = '0;
        end
    end

    // Counter registers: setup loads, a branch commits the next values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lc_q <= '0;
            ec_q <= '0;
        end else if (setup_en) begin
            lc_q <= setup_lc;
            ec_q <= setup_ec;
        end else if (br_valid) begin
            lc_q <= lc_d;
            ec_q <= ec_d;
        end
    end

    assign br_taken = br_valid & ~setup_en & taken_raw;
    assign lc_value = lc_q;
    assign ec_value = ec_q;

    AST_WHILE_KEEPS_LC: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !setup_en && br_mode == MODE_WHILE) |=> (lc_q == $past(lc_q))); // R9
    AST_EC_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !setup_en) |=> (ec_q <= $past(ec_q))); // R7
    AST_LAST_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_mode == MODE_COUNTED && lc_q == '0 && ec_q <= EC_ONE) |-> !br_taken); // R8
    AST_TAKEN_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> br_valid); // R11
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_valid && !setup_en) |=> ($stable(lc_q) && $stable(ec_q))); // R11
endmodule

// File: rtl/rotating_loop_ctrl.sv
// Top: rotating register loop controller.
// Combines the loop decision, the two rotation bases and the stage-predicate
// storage. A branch always rotates both regions. A setup strobe has priority
// over a branch in the same cycle.
// Assumes: rename lookups are combinational and used in the same cycle.
module rotating_loop_ctrl
    import rlc_pkg::*;
#(
    parameter int LC_W     = 16,
    parameter int EC_W     = 6,
    parameter int GR_FIRST = 32,
    parameter int GR_ROT   = 96,
    parameter int PR_FIRST = 16,
    parameter int PR_ROT   = 48
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            setup_en,
    input  logic [LC_W-1:0] setup_lc,
    input  logic [EC_W-1:0] setup_ec,
    input  logic            br_valid,
    input  logic            br_mode,
    input  logic            br_qp,
    input  logic [6:0]      gr_log_idx,
    output logic [6:0]      gr_phys_idx,
    input  logic [5:0]      pr_log_idx,
    output logic [5:0]      pr_phys_idx,
    output logic            pr_value,
    output logic            br_taken,
    output logic [LC_W-1:0] lc_value,
    output logic [EC_W-1:0] ec_value
);
    localparam int GR_W = $clog2(GR_FIRST + GR_ROT);
    localparam int PR_W = $clog2(PR_FIRST + PR_ROT);
    localparam logic [PR_W-1:0] PR_LAST = PR_W'(PR_FIRST + PR_ROT - 1);

    logic                       rotate;
    logic                       stage_bit;
    logic [0:0][GR_W-1:0]       gr_log_v, gr_phys_v;
    logic [1:0][PR_W-1:0]       pr_log_v, pr_phys_v;

    assign rotate = br_valid & ~setup_en;

    // Lookup vectors: port 0 serves the caller, port 1 finds the slot of the top predicate.
    always_comb begin
        gr_log_v[0] = GR_W'(gr_log_idx);
        pr_log_v[0] = PR_W'(pr_log_idx);
        pr_log_v[1] = PR_LAST;
        gr_phys_idx = 7'(gr_phys_v[0]);
        pr_phys_idx = 6'(pr_phys_v[0]);
    end

    rlc_loop_ctl #(
        .LC_W (LC_W),
        .EC_W (EC_W)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .setup_en  (setup_en),
        .setup_lc  (setup_lc),
        .setup_ec  (setup_ec),
        .br_valid  (br_valid),
        .br_mode   (loop_mode_e'(br_mode)),
        .br_qp     (br_qp),
        .br_taken  (br_taken),
        .stage_bit (stage_bit),
        .lc_value  (lc_value),
        .ec_value  (ec_value)
    );

    rlc_rot_base #(
        .FIRST  (GR_FIRST),
        .NROT   (GR_ROT),
        .IDX_W  (GR_W),
        .NPORTS (1)
    ) u_gr_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (setup_en),
        .rotate   (rotate),
        .log_idx  (gr_log_v),
        .phys_idx (gr_phys_v)
    );

    rlc_rot_base #(
        .FIRST  (PR_FIRST),
        .NROT   (PR_ROT),
        .IDX_W  (PR_W),
        .NPORTS (2)
    ) u_pr_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (setup_en),
        .rotate   (rotate),
        .log_idx  (pr_log_v),
        .phys_idx (pr_phys_v)
    );

    rlc_pred_file #(
        .FIRST (PR_FIRST),
        .NROT  (PR_ROT),
        .IDX_W (PR_W)
    ) u_pred (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (setup_en),
        .rotate    (rotate),
        .stage_bit (stage_bit),
        .wr_phys   (pr_phys_v[1]),
        .rd_phys   (pr_phys_v[0]),
        .rd_val    (pr_value)
    );

    AST_TAKEN_ONLY_ROTATING: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> rotate); // R10
    AST_LOW_PRED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(pr_log_idx) < PR_FIRST) |-> (!pr_value && pr_phys_idx == pr_log_idx)); // R4
    AST_LOW_GR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(gr_log_idx) < GR_FIRST) |-> (gr_phys_idx == gr_log_idx)); // R2
endmodule

// File: tb/tb_rotating_loop_ctrl.sv
// Bench: a vector table walked by one loop, then directed tests.
module tb_rotating_loop_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        setup_en = 1'b0;
    logic [15:0] setup_lc = '0;
    logic [5:0]  setup_ec = '0;
    logic        br_valid = 1'b0;
    logic        br_mode = 1'b0;
    logic        br_qp = 1'b0;
    logic [6:0]  gr_log_idx = '0;
    logic [6:0]  gr_phys_idx;
    logic [5:0]  pr_log_idx = '0;
    logic [5:0]  pr_phys_idx;
    logic        pr_value;
    logic        br_taken;
    logic [15:0] lc_value;
    logic [5:0]  ec_value;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Bench model, derived from the requirements.
    int gbase_m = 0;
    int pbase_m = 0;
    int lc_m = 0;
    int ec_m = 0;
    logic [47:0] pm = '0;

    rotating_loop_ctrl dut (
        .clk(clk), .rst_n(rst_n), .setup_en(setup_en), .setup_lc(setup_lc),
        .setup_ec(setup_ec), .br_valid(br_valid), .br_mode(br_mode), .br_qp(br_qp),
        .gr_log_idx(gr_log_idx), .gr_phys_idx(gr_phys_idx), .pr_log_idx(pr_log_idx),
        .pr_phys_idx(pr_phys_idx), .pr_value(pr_value), .br_taken(br_taken),
        .lc_value(lc_value), .ec_value(ec_value)
    );

    always #10 clk = ~clk;

    // Vector: [25] mode, [24] qp, [23] taken, [22:7] lc after, [6:1] ec after, [0] p16 after.
    localparam logic [25:0] VEC [0:8] = '{
        {1'b0, 1'b0, 1'b1, 16'd1, 6'd3, 1'b1},
        {1'b0, 1'b0, 1'b1, 16'd0, 6'd3, 1'b1},
        {1'b0, 1'b0, 1'b1, 16'd0, 6'd2, 1'b0},
        {1'b0, 1'b0, 1'b1, 16'd0, 6'd1, 1'b0},
        {1'b0, 1'b0, 1'b0, 16'd0, 6'd0, 1'b0},
        {1'b0, 1'b0, 1'b0, 16'd0, 6'd0, 1'b0},
        {1'b1, 1'b1, 1'b1, 16'd0, 6'd0, 1'b1},
        {1'b1, 1'b1, 1'b1, 16'd0, 6'd0, 1'b1},
        {1'b1, 1'b0, 1'b0, 16'd0, 6'd0, 1'b0}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int gr_exp(input int l);
        return (l < 32) ? l : 32 + ((l - 32 + gbase_m) % 96);
    endfunction

    function automatic int pr_exp(input int l);
        return (l < 16) ? l : 16 + ((l - 16 + pbase_m) % 48);
    endfunction

    // Model of one branch from R6 to R9; returns the expected decision.
    function automatic bit model_branch(input bit mode, input bit qp);
        bit go, tk, st;
        go = mode ? qp : (lc_m != 0);
        tk = 1'b0;
        st = 1'b0;
        if (go) begin
            tk = 1'b1;
            st = 1'b1;
            if (!mode) lc_m = lc_m - 1;
        end else if (ec_m > 1) begin
            tk = 1'b1;
            ec_m = ec_m - 1;
        end else begin
            ec_m = 0;
        end
        pm = {pm[46:0], st};
        gbase_m = (gbase_m + 95) % 96;
        pbase_m = (pbase_m + 47) % 48;
        return tk;
    endfunction

    task automatic do_setup(input int lc, input int ec);
        @(negedge clk);
        setup_en = 1'b1;
        setup_lc = 16'(lc);
        setup_ec = 6'(ec);
        @(posedge clk);
        #1 setup_en = 1'b0;
        lc_m = lc;
        ec_m = ec;
        gbase_m = 0;
        pbase_m = 0;
        pm = '0;
    endtask

    task automatic do_branch(input bit mode, input bit qp, output bit seen);
        @(negedge clk);
        br_valid = 1'b1;
        br_mode = mode;
        br_qp = qp;
        #1 seen = br_taken;
        @(posedge clk);
        #1 br_valid = 1'b0;
    endtask

    task automatic rd_pr(input int idx, output logic v, output int ph);
        pr_log_idx = 6'(idx);
        #1;
        v = pr_value;
        ph = int'(pr_phys_idx);
    endtask

    task automatic rd_gr(input int idx, output int ph);
        gr_log_idx = 7'(idx);
        #1 ph = int'(gr_phys_idx);
    endtask

    // Compare logical predicates p16..p20 with the model pipeline (R5).
    task automatic check_pipe(input string tag);
        logic v;
        int ph;
        for (int k = 0; k < 5; k++) begin
            rd_pr(16 + k, v, ph);
            check(v == pm[k], tag, int'(v), int'(pm[k]));
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic v;
        int ph, ph2, a;
        bit tk;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(lc_value == 0, "R1 lc", int'(lc_value), 0);
        check(ec_value == 0, "R1 ec", int'(ec_value), 0);
        check(br_taken == 0, "R1 taken", int'(br_taken), 0);
        rd_gr(40, ph);
        check(ph == 40, "R1 gbase", ph, 40);
        rd_pr(16, v, ph);
        check(ph == 16 && v == 0, "R1 pbase", ph, 16);
        rd_pr(63, v, ph);
        check(v == 0, "R1 p63", int'(v), 0);

        // R6 R7 R8 R9: vector table over a short counted loop, then while mode
        do_setup(2, 3);
        for (int i = 0; i < 9; i++) begin
            logic [25:0] e;
            bit et;
            e = VEC[i];
            et = model_branch(e[25], e[24]);
            do_branch(e[25], e[24], tk);
            check(tk == e[23] && et == e[23], "R6/R7/R8/R9 taken", int'(tk), int'(e[23]));
            check(lc_value == e[22:7], "R6/R9 lc", int'(lc_value), int'(e[22:7]));
            check(ec_value == e[6:1], "R7/R8 ec", int'(ec_value), int'(e[6:1]));
            rd_pr(16, v, ph);
            check(v == e[0], "R5 p16", int'(v), int'(e[0]));
            check_pipe("R5 pipe");
            rd_gr(32, ph);
            check(ph == gr_exp(32), "R2 r32", ph, gr_exp(32));
            rd_gr(127, ph);
            check(ph == gr_exp(127), "R2 r127", ph, gr_exp(127));
            rd_pr(63, v, ph);
            check(ph == pr_exp(63), "R4 p63", ph, pr_exp(63));
        end

        // R3: the register named r32 before a branch is r33 after it
        do_setup(5, 1);
        rd_gr(32, ph);
        check(ph == 32, "R3 base0", ph, 32);
        tk = model_branch(1'b0, 1'b0);
        do_branch(1'b0, 1'b0, tk);
        rd_gr(33, ph2);
        check(ph2 == ph, "R3 r33", ph2, ph);
        rd_gr(32, ph);
        check(ph == 127, "R3 wrap", ph, 127);
        rd_gr(7, ph);
        check(ph == 7, "R2 static", ph, 7);
        rd_pr(16, v, ph);
        check(ph == 63, "R4 wrap", ph, 63);
        rd_pr(3, v, ph);
        check(ph == 3 && v == 0, "R4 static", ph, 3);

        // R11: an idle cycle changes nothing
        rd_gr(50, ph);
        a = int'(lc_value);
        @(negedge clk);
        @(negedge clk);
        check(int'(lc_value) == a, "R11 idle lc", int'(lc_value), a);
        rd_gr(50, ph2);
        check(ph2 == ph, "R11 idle base", ph2, ph);
        check_pipe("R11 idle pipe");
        check(br_taken == 0, "R11 no valid", int'(br_taken), 0);

        // R9: while mode with a nonzero loop count leaves it unchanged
        a = int'(lc_value);
        tk = model_branch(1'b1, 1'b1);
        do_branch(1'b1, 1'b1, tk);
        check(int'(lc_value) == a, "R9 lc held", int'(lc_value), a);
        check(ec_value == 1, "R9 ec held", int'(ec_value), 1);

        // R10: setup wins over a branch in the same cycle
        @(negedge clk);
        setup_en = 1'b1;
        setup_lc = 16'd9;
        setup_ec = 6'd4;
        br_valid = 1'b1;
        br_mode = 1'b0;
        #1 tk = br_taken;
        check(tk == 0, "R10 taken", int'(tk), 0);
        @(posedge clk);
        #1 setup_en = 1'b0;
        br_valid = 1'b0;
        lc_m = 9; ec_m = 4; gbase_m = 0; pbase_m = 0; pm = '0;
        check(lc_value == 9, "R10 lc", int'(lc_value), 9);
        check(ec_value == 4, "R10 ec", int'(ec_value), 4);
        rd_gr(32, ph);
        check(ph == 32, "R10 gbase", ph, 32);
        check_pipe("R10 pipe");

        // R5: many branches keep the pipeline model aligned across wraps
        for (int i = 0; i < 60; i++) begin
            bit et;
            et = model_branch(1'b0, 1'b0);
            do_branch(1'b0, 1'b0, tk);
            if (tk != et) check(1'b0, "R6/R7/R8 long", int'(tk), int'(et));
        end
        check_pipe("R5 long");
        rd_gr(100, ph);
        check(ph == gr_exp(100), "R3 long", ph, gr_exp(100));
        rd_pr(40, v, ph);
        check(ph == pr_exp(40), "R4 long", ph, pr_exp(40));

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule